// File: doc/BRIEF.md
# Grouped GPIO interrupt controller

The block watches several banks of general-purpose input pins and merges them into a single interrupt request for a host processor. Every pin has its own trigger setting: rising edge, falling edge, either edge, high level or low level. When a pin's trigger condition is seen, a sticky pending bit for that pin is set. Software reads the pending and mask words to find which pin fired, then clears pending bits by writing ones to them.

Each bank owns one 32-bit word in each of three register arrays: trigger configuration, mask and pending. The arrays sit at fixed byte offsets, and the bank number selects the word inside each array. A mask bit blocks the pin from the interrupt output but does not stop the pin from recording pending events. The interrupt output is high while any bank has a pending bit whose mask bit is clear.

Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. The register port has a byte address, a write enable, write data, and read data that is combinational from the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every mask bit reads 1, every pending bit reads 0, every configuration field reads 0, and `irq_o` is low.
- R2: Each bank g has three words: configuration at byte address 0x700+4g, mask at 0x900+4g and pending at 0xA00+4g. Pin n of a bank owns bit n of the mask and pending words. In the configuration word, pin n owns the trigger code in bits 4n+2..4n. Bit 4n+3 and mask bits 31..8 read 0. Configuration and mask change only when written.
- R3: Reads of addresses that hit none of those words return 0, including misaligned addresses and banks past the last one. Writes to such addresses change no register.
- R4: Trigger code 3 detects a rising edge. A pin change that is present at clock edge k sets the pending bit at edge k+2. A pending bit is set only by a detected event.
- R5: Trigger code 2 detects a falling edge, and code 4 detects both edges.
- R6: Code 1 (level high) and code 0 (level low) set the pending bit on every clock while the level is active, so a clear has no lasting effect until the pin goes inactive. With the reset configuration, a low pin records a pending event.
- R7: Trigger codes 5, 6 and 7 never set a pending bit.
- R8: Writing 1 to a pending bit clears it at that clock edge. Pending bits written with 0 keep their value.
- R9: If a detected event and a clear write hit the same pending bit at the same clock edge, the bit ends up set.
- R10: A mask bit of 1 keeps its pin out of `irq_o`, but that pin still records pending events. Clearing the mask bit raises `irq_o` at once when the bit is pending.
- R11: `irq_o` is the OR over all banks of pending AND NOT mask, taken straight from the registers with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (12) | Byte address of the register word |
| wr_en_i | input | 1 | Write strobe, acts at the rising clock edge |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| pins_i | input | NUM_BANKS*PINS_PER_BANK (32) | Raw pin inputs, bank g pin n at index g*PINS_PER_BANK+n |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pin change must show in the pending word and in `irq_o` exactly at the third clock edge after it is applied: two edges of synchronizer and one of pending register. The bench checks the low value after the first and second edges and the high value after the third. Register writes act at the next edge, and both read data and the interrupt follow from register state with no delay. So the bench drives inputs just after a falling edge, lets its behavioural model advance at each rising edge, and compares `irq_o` and `rd_data_o` with the model at every falling edge. The same-edge collision between a set and a clear is placed by counting edges from the pin change. This places the clear write on the edge where the pending bit is set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int TRIG_W  = 3;
  localparam int FIELD_W = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  localparam int CFG_BASE_DEF  = 'h700;
  localparam int MASK_BASE_DEF = 'h900;
  localparam int PEND_BASE_DEF = 'hA00;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0]        sync_i,
  input  logic [PINS-1:0]        prev_i,
  input  logic [PINS*TRIG_W-1:0] trig_i,
  output logic [PINS-1:0]        event_o
);

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    logic [TRIG_W-1:0] code;
    assign code = trig_i[n*TRIG_W +: TRIG_W];

    always_comb begin
      case (code)
        TRIG_LVL_LO: event_o[n] = ~sync_i[n];
        TRIG_LVL_HI: event_o[n] =  sync_i[n];
        TRIG_FALL:   event_o[n] = ~sync_i[n] &  prev_i[n];
        TRIG_RISE:   event_o[n] =  sync_i[n] & ~prev_i[n];
        TRIG_BOTH:   event_o[n] =  sync_i[n] ^  prev_i[n];
        default:     event_o[n] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic                   mask_we_i,
  input  logic                   pend_we_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [PINS-1:0]        event_i,
  output logic [PINS*TRIG_W-1:0] trig_o,
  output logic [DATA_W-1:0]      cfg_rd_o,
  output logic [DATA_W-1:0]      mask_rd_o,
  output logic [DATA_W-1:0]      pend_rd_o,
  output logic                   hit_o
);

  localparam int PAD_W = DATA_W - PINS;

  logic [PINS*TRIG_W-1:0] cfg_q, cfg_d;
  logic [PINS-1:0]        mask_q, pend_q, clr;
  logic                   unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar n = 0; n < PINS; n++) begin : g_cfg
    assign cfg_d[n*TRIG_W +: TRIG_W] = wdata_i[n*FIELD_W +: TRIG_W];
  end

  assign clr = pend_we_i ? wdata_i[PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (cfg_we_i)  cfg_q  <= cfg_d;
      if (mask_we_i) mask_q <= wdata_i[PINS-1:0];
      // event set has priority over write-one-to-clear
      pend_q <= (pend_q & ~clr) | event_i;
    end
  end

  always_comb begin
    cfg_rd_o = '0;
    for (int n = 0; n < PINS; n++) begin
      cfg_rd_o[n*FIELD_W +: TRIG_W] = cfg_q[n*TRIG_W +: TRIG_W];
    end
  end

  assign trig_o    = cfg_q;
  assign mask_rd_o = {{PAD_W{1'b0}}, mask_q};
  assign pend_rd_o = {{PAD_W{1'b0}}, pend_q};
  assign hit_o     = |(pend_q & ~mask_q);

  assert_event_sets_pend_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((pend_q & $past(event_i)) == $past(event_i)));

  assert_w1c_clears_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (pend_we_i && |(wdata_i[PINS-1:0] & ~event_i))
      |=> ((pend_q & $past(wdata_i[PINS-1:0] & ~event_i)) == '0));

  assert_pend_needs_event_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((pend_q & ~$past(pend_q) & ~$past(event_i)) == '0));

  assert_cfg_holds_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q));

  assert_mask_holds_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 8,
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int CFG_BASE      = CFG_BASE_DEF,
  parameter int MASK_BASE     = MASK_BASE_DEF,
  parameter int PEND_BASE     = PEND_BASE_DEF
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic                               wr_en_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic [DATA_W-1:0]                  rd_data_o,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pins_i,
  output logic                               irq_o
);

  localparam int NPINS      = NUM_BANKS * PINS_PER_BANK;
  localparam int WORD_BYTES = DATA_W / 8;

  logic [NPINS-1:0]  sync_w, prev_w;
  logic [DATA_W-1:0] cfg_rd  [NUM_BANKS];
  logic [DATA_W-1:0] mask_rd [NUM_BANKS];
  logic [DATA_W-1:0] pend_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] cfg_sel, mask_sel, pend_sel, bank_hit;

  gpio_irq_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (pins_i),
    .sync_o (sync_w),
    .prev_o (prev_w)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_BASE  + g*WORD_BYTES);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_BASE + g*WORD_BYTES);
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_BASE + g*WORD_BYTES);

    logic [PINS_PER_BANK-1:0]        evt;
    logic [PINS_PER_BANK*TRIG_W-1:0] trig;

    assign cfg_sel[g]  = (addr_i == CFG_A);
    assign mask_sel[g] = (addr_i == MASK_A);
    assign pend_sel[g] = (addr_i == PEND_A);

    gpio_irq_detect #(.PINS(PINS_PER_BANK)) u_detect (
      .sync_i  (sync_w[g*PINS_PER_BANK +: PINS_PER_BANK]),
      .prev_i  (prev_w[g*PINS_PER_BANK +: PINS_PER_BANK]),
      .trig_i  (trig),
      .event_o (evt)
    );

    gpio_irq_bank #(.PINS(PINS_PER_BANK), .DATA_W(DATA_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (wr_en_i & cfg_sel[g]),
      .mask_we_i (wr_en_i & mask_sel[g]),
      .pend_we_i (wr_en_i & pend_sel[g]),
      .wdata_i   (wr_data_i),
      .event_i   (evt),
      .trig_o    (trig),
      .cfg_rd_o  (cfg_rd[g]),
      .mask_rd_o (mask_rd[g]),
      .pend_rd_o (pend_rd[g]),
      .hit_o     (bank_hit[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NUM_BANKS; g++) begin
      if (cfg_sel[g])  rd_data_o |= cfg_rd[g];
      if (mask_sel[g]) rd_data_o |= mask_rd[g];
      if (pend_sel[g]) rd_data_o |= pend_rd[g];
    end
  end

  assign irq_o = |bank_hit;

  assert_one_word_selected_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_sel, mask_sel, pend_sel}));

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

  localparam int NB = 4;
  localparam int PP = 8;
  localparam int NP = NB * PP;
  localparam logic [11:0] CFG  = 12'h700;
  localparam logic [11:0] MSK  = 12'h900;
  localparam logic [11:0] PND  = 12'hA00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [NP-1:0] pins = '0;
  logic        irq;

  int total = 0;
  int failed = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wdata),
    .rd_data_o (rd_data),
    .pins_i    (pins),
    .irq_o     (irq)
  );

  // behavioural reference
  bit          m_s1 [NP];
  bit          m_s2 [NP];
  bit          m_pv [NP];
  logic [31:0] m_cfg  [NB];
  logic [7:0]  m_mask [NB];
  logic [7:0]  m_pend [NB];
  logic [7:0]  m_ev   [NB];

  function automatic logic [31:0] model_read(logic [11:0] a);
    for (int g = 0; g < NB; g++) begin
      if (a == CFG + 12'(4*g)) return m_cfg[g];
      if (a == MSK + 12'(4*g)) return {24'h0, m_mask[g]};
      if (a == PND + 12'(4*g)) return {24'h0, m_pend[g]};
    end
    return 32'h0;
  endfunction

  function automatic bit model_irq();
    bit r = 1'b0;
    for (int g = 0; g < NB; g++) r |= |(m_pend[g] & ~m_mask[g]);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0;
      end
      for (int g = 0; g < NB; g++) begin
        m_cfg[g] = 0; m_mask[g] = 8'hFF; m_pend[g] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        int code;
        bit e;
        code = int'(m_cfg[p/PP][4*(p%PP) +: 3]);
        case (code)
          0: e = !m_s2[p];
          1: e = m_s2[p];
          2: e = !m_s2[p] && m_pv[p];
          3: e = m_s2[p] && !m_pv[p];
          4: e = m_s2[p] != m_pv[p];
          default: e = 0;
        endcase
        m_ev[p/PP][p%PP] = e;
      end
      for (int g = 0; g < NB; g++) begin
        logic [7:0] clr;
        clr = (wr_en && addr == PND + 12'(4*g)) ? wdata[7:0] : 8'h0;
        m_pend[g] = (m_pend[g] & ~clr) | m_ev[g];
        if (wr_en && addr == CFG + 12'(4*g)) m_cfg[g] = wdata & 32'h77777777;
        if (wr_en && addr == MSK + 12'(4*g)) m_mask[g] = wdata[7:0];
      end
      for (int p = 0; p < NP; p++) begin
        m_pv[p] = m_s2[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pins[p];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      check(cur_req, {31'h0, irq}, {31'h0, model_irq()});
      check(cur_req, rd_data, model_read(addr));
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic clear_all();
    for (int g = 0; g < NB; g++) wr(PND + 12'(4*g), 32'hFF);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 while reset is held
    rd_chk("R1", MSK, 32'hFF);
    rd_chk("R1", MSK + 12'd12, 32'hFF);
    rd_chk("R1", PND, 32'h0);
    rd_chk("R1", CFG + 12'd8, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);
    step();
    rst_n = 1'b1;
    running = 1'b1;

    // R6: reset config is level low, low pins record pending
    cur_req = "R6";
    step(3);
    rd_chk("R6", PND + 12'd4, 32'hFF);

    cur_req = "R2";
    wr(CFG + 12'd4, 32'hFFFFFFFF);
    rd_chk("R2", CFG + 12'd4, 32'h77777777);
    wr(MSK + 12'd4, 32'hFFFFFF5A);
    rd_chk("R2", MSK + 12'd4, 32'h5A);
    wr(MSK + 12'd4, 32'hFF);
    for (int g = 0; g < NB; g++) wr(CFG + 12'(4*g), 32'h33333333);
    clear_all();
    rd_chk("R2", CFG + 12'd12, 32'h33333333);
    rd_chk("R8", PND + 12'd8, 32'h0);

    cur_req = "R3";
    wr(12'h800, 32'h1234);
    rd_chk("R3", 12'h800, 32'h0);
    rd_chk("R3", 12'h701, 32'h0);
    rd_chk("R3", CFG + 12'd16, 32'h0);
    wr(12'h901, 32'h0);
    rd_chk("R3", MSK, 32'hFF);

    // R4 rising edge and latency
    cur_req = "R4";
    wr(MSK, 32'h0);
    pins[0] = 1'b1;
    step(); check("R4", {31'h0, irq}, 32'h0);
    step(); check("R4", {31'h0, irq}, 32'h0);
    step(); check("R4", {31'h0, irq}, 32'h1);
    rd_chk("R4", PND, 32'h01);
    cur_req = "R8";
    wr(PND, 32'h00);
    rd_chk("R8", PND, 32'h01);
    wr(PND, 32'h01);
    rd_chk("R8", PND, 32'h0);
    check("R8", {31'h0, irq}, 32'h0);
    cur_req = "R4";
    pins[0] = 1'b0;
    step(4);
    rd_chk("R4", PND, 32'h0);

    // R5 falling on pin1, both on pin2
    cur_req = "R5";
    wr(CFG, 32'h33333423);
    pins[1] = 1'b1; pins[2] = 1'b1;
    step(4);
    rd_chk("R5", PND, 32'h04);
    clear_all();
    pins[1] = 1'b0; pins[2] = 1'b0;
    step(4);
    rd_chk("R5", PND, 32'h06);
    clear_all();

    // R6 level high pin8, level low pin9
    cur_req = "R6";
    wr(CFG + 12'd4, 32'h33333301);
    step(4);
    clear_all();
    rd_chk("R6", PND + 12'd4, 32'h02);
    pins[8] = 1'b1; pins[9] = 1'b1;
    step(4);
    clear_all();
    rd_chk("R6", PND + 12'd4, 32'h01);
    pins[8] = 1'b0;
    step(4);
    wr(CFG + 12'd4, 32'h33333333);
    clear_all();
    rd_chk("R6", PND + 12'd4, 32'h0);

    // R7 unused codes
    cur_req = "R7";
    wr(CFG + 12'd8, 32'h33335765);
    pins[19:16] = 4'hF;
    step(5);
    pins[19:16] = 4'h0;
    step(5);
    rd_chk("R7", PND + 12'd8, 32'h0);

    // R9 set and clear on the same edge
    cur_req = "R9";
    pins[3] = 1'b1;
    step(2);
    wr(PND, 32'h08);
    rd_chk("R9", PND, 32'h08);
    wr(PND, 32'h08);
    rd_chk("R9", PND, 32'h0);

    // R10 mask
    cur_req = "R10";
    wr(MSK, 32'h10);
    pins[4] = 1'b1;
    step(4);
    check("R10", {31'h0, irq}, 32'h0);
    rd_chk("R10", PND, 32'h10);
    wr(MSK, 32'h0);
    check("R10", {31'h0, irq}, 32'h1);
    clear_all();

    // R11 other bank drives the output
    cur_req = "R11";
    wr(MSK, 32'hFF);
    wr(MSK + 12'd12, 32'h0);
    pins[24] = 1'b1;
    step(4);
    check("R11", {31'h0, irq}, 32'h1);
    rd_chk("R11", PND + 12'd12, 32'h01);
    wr(PND + 12'd12, 32'h01);
    check("R11", {31'h0, irq}, 32'h0);

    // mixed random traffic, compared against the model every clock
    for (int i = 0; i < 3000; i++) begin
      int sel;
      pins = pins ^ NP'($urandom & $urandom & $urandom);
      sel = int'($urandom % 16);
      if (sel < 3) begin
        wr(CFG + 12'(4 * ($urandom % NB)), $urandom);
      end else if (sel < 5) begin
        wr(MSK + 12'(4 * ($urandom % NB)), $urandom);
      end else if (sel < 9) begin
        wr(PND + 12'(4 * ($urandom % NB)), $urandom);
      end else begin
        addr = 12'h700 + 12'($urandom % 12'h320);
        step();
      end
    end

    step(2);
    running = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule